// File: doc/BRIEF.md
# Unified Address Translation Buffer with Pinned Entries

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KB pages. Instruction fetches and data accesses both use it through one lookup port; there is no split between the two kinds of access. A lookup is combinational. It takes a virtual address and returns the physical address, formed from the cached physical page number and the untouched 12-bit page offset, together with a hit flag.

Storage is split into two regions. The pinned region has eight slots and is fully associative. A pinned entry can be removed only by writing over its slot or by an address-matched invalidate. The general region is 2-way set associative with 16 sets, indexed by the low four bits of the virtual page number. Each set keeps its own round-robin victim pointer. The refill port chooses the region for each write through a pin-select input that is sampled in the write cycle. When pinned writes are selected, a 3-bit slot number names the slot to be written.

While translation is switched off, the physical address equals the virtual address and the cached contents are ignored. Switching translation off and back on leaves the contents as they were.

Top module: `utlb_top`

## Requirements
- R1: With translation on, a lookup whose page number matches a valid entry returns lk_hit=1 and lk_pa = {stored physical page, lk_va[11:0]} in the same cycle. A lookup with no matching valid entry returns lk_hit=0. The cached state seen is the one before the current clock edge.
- R2: With mmu_on=0, lk_pa equals lk_va and lk_hit is 1, whatever the cached contents are.
- R3: A refill with fill_lock=1 writes slot fill_slot of the pinned region. That entry then hits on later lookups.
- R4: A refill with fill_lock=0 goes into set fill_vpn[3:0] of the general region. When that page is not already present, it is placed in the way named by the set's round-robin pointer, which starts at way 0 after reset and then advances. The third distinct page filled into one set therefore evicts the first.
- R5: A general refill of a page that is already present in its set overwrites that way and leaves the set's pointer unchanged.
- R6: When both regions match a page, the pinned entry supplies the physical page. Among duplicate pinned matches, the lowest slot wins.
- R7: inv_all clears every general-region entry and leaves every pinned entry valid.
- R8: inv_one clears every entry in both regions whose page equals inv_vpn, and only those entries.
- R9: Toggling mmu_on off and back on changes no cached entry.
- R10: A refill in the same cycle as inv_all or inv_one takes effect: the written entry is valid afterwards. The invalidate applies to all other entries.
- R11: After reset, no lookup hits with translation on.
- R12: A pinned refill to an occupied slot replaces that slot's earlier entry, and the earlier page then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_on | input | 1 | Translation enable; 0 gives flat mapping |
| lk_va | input | 32 | Lookup virtual address |
| lk_pa | output | 32 | Translated (or flat) physical address |
| lk_hit | output | 1 | Lookup hit (always 1 when flat) |
| fill_we | input | 1 | Refill write strobe |
| fill_lock | input | 1 | 1 selects the pinned region for this refill |
| fill_slot | input | 3 | Pinned slot number used when fill_lock=1 |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page number |
| inv_all | input | 1 | Invalidate the whole general region |
| inv_one | input | 1 | Invalidate entries matching inv_vpn in both regions |
| inv_vpn | input | 20 | Page number for inv_one |

## Verification
A refill can arrive in the same cycle as either kind of invalidate, and a lookup can occur in the same cycle as a refill or invalidate of the page it asks for. The random phase drives all four commands independently on each cycle. It draws pages from a small pool so that collisions are frequent, and directed steps pair a refill with an inv_one of the same page and with inv_all. A bench model judges the outcome: it applies the cycle's invalidates before its refill, and it gives a same-cycle lookup the state from before the edge.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VA_W  = 32;
  localparam int PG_W  = 12;
  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = 20;

  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PPN_W-1:0] ppn_t;
  typedef logic [VA_W-1:0]  addr_t;

  function automatic vpn_t page_of(addr_t a);
    return a[VA_W-1:PG_W];
  endfunction

  function automatic addr_t join_pa(ppn_t p, addr_t a);
    return {p, a[PG_W-1:0]};
  endfunction
endpackage

// File: rtl/utlb_lock_bank.sv
module utlb_lock_bank
  import utlb_pkg::*;
#(
  parameter int N = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] we_slot,
  input  vpn_t          we_vpn,
  input  ppn_t          we_ppn,
  input  logic          inv_en,
  input  vpn_t          inv_vpn,
  input  vpn_t          rd_vpn,
  output logic          rd_hit,
  output ppn_t          rd_ppn
);
  logic [N-1:0] vld;
  vpn_t tag [N];
  ppn_t pn  [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (inv_en && vld[i] && tag[i] == inv_vpn) vld[i] <= 1'b0;
        if (we && we_slot == SW'(i)) vld[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (we && we_slot == SW'(i)) begin
        tag[i] <= we_vpn;
        pn[i]  <= we_ppn;
      end
    end
  end

  // lowest matching slot wins
  always_comb begin
    rd_hit = 1'b0;
    rd_ppn = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && tag[i] == rd_vpn) begin
        rd_hit = 1'b1;
        rd_ppn = pn[i];
      end
    end
  end
endmodule

// File: rtl/utlb_set_bank.sv
module utlb_set_bank
  import utlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  localparam int IW = $clog2(SETS),
  localparam int PW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  vpn_t we_vpn,
  input  ppn_t we_ppn,
  input  logic inv_all,
  input  logic inv_en,
  input  vpn_t inv_vpn,
  input  vpn_t rd_vpn,
  output logic rd_hit,
  output ppn_t rd_ppn
);
  logic [WAYS-1:0] vld [SETS];
  vpn_t            tag [SETS][WAYS];
  ppn_t            pn  [SETS][WAYS];
  logic [PW-1:0]   rr  [SETS];

  logic [IW-1:0] ridx, widx, iidx;
  logic [PW-1:0] wway;
  logic          wm_any;

  assign ridx = rd_vpn[IW-1:0];
  assign widx = we_vpn[IW-1:0];
  assign iidx = inv_vpn[IW-1:0];

  // refill target: existing copy of the page first, else the round-robin way
  always_comb begin
    wm_any = 1'b0;
    wway   = rr[widx];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[widx][w] && tag[widx][w] == we_vpn) begin
        wm_any = 1'b1;
        wway   = PW'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
    end else begin
      if (inv_all)
        for (int s = 0; s < SETS; s++) vld[s] <= '0;
      if (inv_en)
        for (int w = 0; w < WAYS; w++)
          if (vld[iidx][w] && tag[iidx][w] == inv_vpn) vld[iidx][w] <= 1'b0;
      if (we) begin
        vld[widx][wway] <= 1'b1;
        if (!wm_any)
          rr[widx] <= (rr[widx] == PW'(WAYS - 1)) ? '0 : rr[widx] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag[widx][wway] <= we_vpn;
      pn[widx][wway]  <= we_ppn;
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_ppn = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[ridx][w] && tag[ridx][w] == rd_vpn) begin
        rd_hit = 1'b1;
        rd_ppn = pn[ridx][w];
      end
    end
  end
endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int LOCK_N = 8,
  parameter int SETS   = 16,
  parameter int WAYS   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mmu_on,
  input  logic [31:0]               lk_va,
  output logic [31:0]               lk_pa,
  output logic                      lk_hit,
  input  logic                      fill_we,
  input  logic                      fill_lock,
  input  logic [$clog2(LOCK_N)-1:0] fill_slot,
  input  logic [19:0]               fill_vpn,
  input  logic [19:0]               fill_ppn,
  input  logic                      inv_all,
  input  logic                      inv_one,
  input  logic [19:0]               inv_vpn
);
  vpn_t rd_vpn;
  logic lock_hit, set_hit;
  ppn_t lock_ppn, set_ppn, sel_ppn;
  logic lock_we, set_we;

  assign rd_vpn  = page_of(lk_va);
  assign lock_we = fill_we & fill_lock;
  assign set_we  = fill_we & ~fill_lock;

  utlb_lock_bank #(.N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .we(lock_we), .we_slot(fill_slot), .we_vpn(fill_vpn), .we_ppn(fill_ppn),
    .inv_en(inv_one), .inv_vpn(inv_vpn),
    .rd_vpn(rd_vpn), .rd_hit(lock_hit), .rd_ppn(lock_ppn)
  );

  utlb_set_bank #(.SETS(SETS), .WAYS(WAYS)) u_set (
    .clk(clk), .rst_n(rst_n),
    .we(set_we), .we_vpn(fill_vpn), .we_ppn(fill_ppn),
    .inv_all(inv_all), .inv_en(inv_one), .inv_vpn(inv_vpn),
    .rd_vpn(rd_vpn), .rd_hit(set_hit), .rd_ppn(set_ppn)
  );

  assign sel_ppn = lock_hit ? lock_ppn : set_ppn;
  assign lk_pa   = mmu_on ? join_pa(sel_ppn, lk_va) : lk_va;
  assign lk_hit  = mmu_on ? (lock_hit | set_hit) : 1'b1;
endmodule

// File: rtl/utlb_chk.sv
module utlb_chk
  import utlb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        mmu_on,
  input logic [31:0] lk_va,
  input logic [31:0] lk_pa,
  input logic        lk_hit,
  input logic        fill_we,
  input logic [19:0] fill_vpn,
  input logic        inv_all,
  input logic        inv_one,
  input logic [19:0] inv_vpn,
  input logic        lock_hit,
  input logic        set_hit,
  input ppn_t        lock_ppn
);
  AST_FLAT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_on |-> (lk_pa == lk_va && lk_hit)); // R2

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> ((mmu_on && page_of(lk_va) == $past(fill_vpn)) -> lk_hit)); // R10

  AST_INV_ONE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one && !(fill_we && fill_vpn == inv_vpn))
      |=> ((mmu_on && page_of(lk_va) == $past(inv_vpn)) -> !lk_hit)); // R8

  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_we) |=> !set_hit); // R7

  AST_PIN_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit && inv_all && !inv_one && !fill_we) |=> ($stable(lk_va) -> lock_hit)); // R7

  AST_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit && mmu_on) |-> (lk_pa[31:12] == lock_ppn)); // R6
endmodule

bind utlb_top utlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mmu_on(mmu_on), .lk_va(lk_va), .lk_pa(lk_pa),
  .lk_hit(lk_hit), .fill_we(fill_we), .fill_vpn(fill_vpn), .inv_all(inv_all),
  .inv_one(inv_one), .inv_vpn(inv_vpn), .lock_hit(lock_hit), .set_hit(set_hit),
  .lock_ppn(lock_ppn)
);

// File: tb/tb_utlb_top.sv
module tb_utlb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmu_on = 1'b0;
  logic [31:0] lk_va = '0;
  logic [31:0] lk_pa;
  logic        lk_hit;
  logic        fill_we = 1'b0, fill_lock = 1'b0;
  logic [2:0]  fill_slot = '0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0, inv_vpn = '0;
  logic        inv_all = 1'b0, inv_one = 1'b0;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  utlb_top dut (
    .clk(clk), .rst_n(rst_n), .mmu_on(mmu_on), .lk_va(lk_va), .lk_pa(lk_pa),
    .lk_hit(lk_hit), .fill_we(fill_we), .fill_lock(fill_lock), .fill_slot(fill_slot),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .inv_all(inv_all), .inv_one(inv_one),
    .inv_vpn(inv_vpn)
  );

  // reference model
  logic        p_v [8];
  logic [19:0] p_t [8], p_p [8];
  logic        g_v [16][2];
  logic [19:0] g_t [16][2], g_p [16][2];
  logic        g_rr [16];

  task automatic model_reset();
    for (int i = 0; i < 8; i++) p_v[i] = 1'b0;
    for (int s = 0; s < 16; s++) begin
      g_v[s][0] = 1'b0; g_v[s][1] = 1'b0; g_rr[s] = 1'b0;
    end
  endtask

  function automatic logic [32:0] expect_lookup(logic on, logic [31:0] va);
    logic [19:0] pg = va[31:12];
    int s = int'(va[15:12]);
    if (!on) return {1'b1, va};
    for (int i = 0; i < 8; i++)
      if (p_v[i] && p_t[i] == pg) return {1'b1, p_p[i], va[11:0]};
    for (int w = 0; w < 2; w++)
      if (g_v[s][w] && g_t[s][w] == pg) return {1'b1, g_p[s][w], va[11:0]};
    return {1'b0, va};
  endfunction

  task automatic model_edge();
    int s = int'(fill_vpn[3:0]);
    int way = int'(g_rr[s]);
    logic found = 1'b0;
    for (int w = 1; w >= 0; w--)
      if (g_v[s][w] && g_t[s][w] == fill_vpn) begin found = 1'b1; way = w; end
    if (inv_all)
      for (int k = 0; k < 16; k++) begin g_v[k][0] = 1'b0; g_v[k][1] = 1'b0; end
    if (inv_one) begin
      for (int i = 0; i < 8; i++) if (p_v[i] && p_t[i] == inv_vpn) p_v[i] = 1'b0;
      for (int k = 0; k < 16; k++)
        for (int w = 0; w < 2; w++) if (g_v[k][w] && g_t[k][w] == inv_vpn) g_v[k][w] = 1'b0;
    end
    if (fill_we) begin
      if (fill_lock) begin
        p_v[fill_slot] = 1'b1; p_t[fill_slot] = fill_vpn; p_p[fill_slot] = fill_ppn;
      end else begin
        g_v[s][way] = 1'b1; g_t[s][way] = fill_vpn; g_p[s][way] = fill_ppn;
        if (!found) g_rr[s] = ~g_rr[s];
      end
    end
  endtask

  task automatic check(string req, logic [32:0] exp);
    checks++;
    if (exp[32] == 1'b0) begin
      if (lk_hit !== 1'b0) begin
        errors++;
        $display("FAIL %s va=%h hit=%b pa=%h expected miss", req, lk_va, lk_hit, lk_pa);
      end
    end else if (lk_hit !== 1'b1 || lk_pa !== exp[31:0]) begin
      errors++;
      $display("FAIL %s va=%h hit=%b pa=%h expected hit=1 pa=%h", req, lk_va, lk_hit, lk_pa, exp[31:0]);
    end
  endtask

  // one cycle: drive, check lookup against pre-edge state, advance model
  task automatic step(string req, logic on, logic [31:0] va,
                      logic fwe, logic flk, logic [2:0] fsl, logic [19:0] fv, logic [19:0] fp,
                      logic ia, logic io, logic [19:0] iv);
    @(negedge clk);
    mmu_on = on; lk_va = va; fill_we = fwe; fill_lock = flk; fill_slot = fsl;
    fill_vpn = fv; fill_ppn = fp; inv_all = ia; inv_one = io; inv_vpn = iv;
    #1;
    check(req, expect_lookup(on, va));
    model_edge();
  endtask

  task automatic look(string req, logic on, logic [19:0] pg, logic [11:0] off);
    step(req, on, {pg, off}, 1'b0, 1'b0, 3'd0, 20'h0, 20'h0, 1'b0, 1'b0, 20'h0);
  endtask

  task automatic gfill(logic [19:0] v, logic [19:0] p);
    step("fill", 1'b1, 32'h0, 1'b1, 1'b0, 3'd0, v, p, 1'b0, 1'b0, 20'h0);
  endtask

  task automatic pfill(logic [2:0] sl, logic [19:0] v, logic [19:0] p);
    step("fill", 1'b1, 32'h0, 1'b1, 1'b1, sl, v, p, 1'b0, 1'b0, 20'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    mmu_on = 1'b1; lk_va = 32'h0001_1abc; #1;
    check("R11 reset", {1'b0, 32'h0});
    rst_n = 1'b1;
    look("R11 after reset", 1'b1, 20'h00011, 12'h123);

    // R4 round robin: three pages in set 1
    gfill(20'h00011, 20'hA0001);
    gfill(20'h00021, 20'hA0002);
    look("R1 hit way1", 1'b1, 20'h00021, 12'h456);
    gfill(20'h00031, 20'hA0003);
    look("R4 first page evicted", 1'b1, 20'h00011, 12'h000);
    look("R4 second kept", 1'b1, 20'h00021, 12'hfff);
    look("R4 third present", 1'b1, 20'h00031, 12'h010);

    // R5 refill of a present page, set 2
    gfill(20'h00012, 20'hB0001);
    gfill(20'h00012, 20'hB0009);
    look("R5 updated ppn", 1'b1, 20'h00012, 12'h111);
    gfill(20'h00022, 20'hB0002);
    look("R5 pointer unchanged keeps page", 1'b1, 20'h00012, 12'h222);
    gfill(20'h00032, 20'hB0003);
    look("R5 then evicted", 1'b1, 20'h00012, 12'h222);

    // R3, R12 pinned slot
    pfill(3'd2, 20'h12345, 20'hC0001);
    look("R3 pinned hit", 1'b1, 20'h12345, 12'hab0);
    pfill(3'd2, 20'h54321, 20'hC0002);
    look("R12 old page miss", 1'b1, 20'h12345, 12'hab0);
    look("R12 new page hit", 1'b1, 20'h54321, 12'h001);

    // R6 pinned wins
    gfill(20'h00044, 20'hD0001);
    pfill(3'd5, 20'h00044, 20'hD0002);
    look("R6 pinned priority", 1'b1, 20'h00044, 12'h777);

    // R2, R9 flat mapping and toggling
    look("R2 flat", 1'b0, 20'h00044, 12'h777);
    look("R2 flat miss page", 1'b0, 20'hFFFFF, 12'h001);
    look("R9 contents kept", 1'b1, 20'h00021, 12'h333);

    // R7 invalidate all
    step("R7 inv_all", 1'b1, 32'h0002_1000, 1'b0, 1'b0, 3'd0, 20'h0, 20'h0, 1'b1, 1'b0, 20'h0);
    look("R7 general gone", 1'b1, 20'h00021, 12'h333);
    look("R7 pinned kept", 1'b1, 20'h54321, 12'h333);

    // R8 invalidate one, both regions
    gfill(20'h00044, 20'hD0003);
    gfill(20'h00055, 20'hD0005);
    step("R8 inv_one", 1'b1, 32'h0, 1'b0, 1'b0, 3'd0, 20'h0, 20'h0, 1'b0, 1'b1, 20'h00044);
    look("R8 matched gone", 1'b1, 20'h00044, 12'h000);
    look("R8 other kept", 1'b1, 20'h00055, 12'h000);

    // R10 refill together with invalidates
    step("R10 fill+inv_one", 1'b1, 32'h0, 1'b1, 1'b0, 3'd0, 20'h00066, 20'hE0006,
         1'b0, 1'b1, 20'h00066);
    look("R10 fill wins inv_one", 1'b1, 20'h00066, 12'h000);
    step("R10 fill+inv_all", 1'b1, 32'h0, 1'b1, 1'b0, 3'd0, 20'h00077, 20'hE0007,
         1'b1, 1'b0, 20'h0);
    look("R10 fill wins inv_all", 1'b1, 20'h00077, 12'h000);
    look("R10 others cleared", 1'b1, 20'h00066, 12'h000);

    // R1 random mix over a small page pool
    for (int n = 0; n < 4000; n++) begin
      logic [19:0] a = {14'h2A5, 6'($urandom)};
      logic [19:0] b = {14'h2A5, 6'($urandom)};
      logic [19:0] c = {14'h2A5, 6'($urandom)};
      logic [31:0] r = $urandom;
      step("R1 random", r[3:0] != 4'd0, {a, 12'($urandom)},
           r[4] | r[5], r[6] & r[7], r[10:8], b, 20'($urandom),
           r[15:11] == 5'd0, r[19:17] == 3'd0, r[20] ? b : c);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule